// File: doc/BRIEF.md
# Complementary PWM Triple Counter Engine

This block produces the timebase for a three-phase complementary PWM stage with six outputs. Two triangle counters run in lockstep a fixed dead-time count apart: the offset counter swings between the dead-time value and the period value, and the base counter swings between zero and the carrier half-cycle value. An auxiliary counter is active only in the two dead-time windows. At the crest it traces a V from the period value down to the half-cycle value and back, and is then cleared to zero. At the trough it rises from zero to the dead-time value and falls back, and is then loaded with the period value. Outside these windows it holds.

Each phase compares its duty input against both triangle counters. The positive output is high while the offset counter is below the duty value. The negative output is high while the base counter is at or above it. Because the two counters are a dead-time count apart, both outputs of a pair stay low for that many steps around every edge. All counters advance on a shared clock-enable input. While the start input is low, or the configuration is illegal, the counters stay preloaded and all six outputs are low.

Top module: `cpwm_engine`

## Requirements
- R1: While `run` is 0, every clock loads `cnt_a` with `dead_time`, `cnt_b` with 0 and `cnt_s` with `dead_time`. It also clears `a_dn` and `b_dn` and sets `s_dn` and `s_act` to 1. Direction flags read 1 for counting down and 0 for counting up. Synchronous reset clears every output to 0.
- R2: When running with `step`=1, `cnt_a` counts up. In the step where it equals `period`, it reverses and moves down. In the step where it equals `dead_time`, it reverses and moves up.
- R3: `cnt_b` moves on the same steps as `cnt_a`. It reverses downward in the step where it equals `half_cycle` and upward in the step where it equals 0, so `cnt_a` always equals `cnt_b + dead_time`.
- R4: When running with `step`=0, all counters and flags hold their values.
- R5: When the auxiliary counter is held and `cnt_a` equals `half_cycle` while counting up, the auxiliary counter starts counting down. When it equals `half_cycle`, it turns up. When it equals `period`, it is cleared to 0 and held (`s_act`=0).
- R6: When the auxiliary counter is held and `cnt_b` equals `dead_time` while counting down, the auxiliary counter starts counting up. When it equals `dead_time`, it turns down. When it equals 0, it is loaded with `period` and held. After the preload, it counts down from `dead_time`.
- R7: A configuration is legal only if `dead_time` > 0, `half_cycle` > 2·`dead_time` and `period` = `half_cycle` + `dead_time`. Otherwise the counters stay preloaded as in R1 and the outputs stay low. `cfg_bad` reports illegality one clock later.
- R8: For phase i, the duty value is `duty[16i+15:16i]`. One clock after a running cycle, `pwm_p[i]` = (`cnt_a` < duty) and `pwm_n[i]` = (`cnt_b` >= duty), using the counter values of that cycle. `pwm_p[i]` and `pwm_n[i]` are never both 1.
- R9: One clock after `run` is 0, all six PWM outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start bit; 0 preloads counters |
| step | input | 1 | Count enable shared by all counters |
| dead_time | input | 16 | Dead-time count |
| half_cycle | input | 16 | Carrier half-cycle count |
| period | input | 16 | Period count (half cycle plus dead time) |
| duty | input | 48 | Three duty values, phase i in bits 16i+15:16i |
| cnt_a | output | 16 | Offset triangle counter |
| cnt_b | output | 16 | Base triangle counter |
| cnt_s | output | 16 | Auxiliary dead-time counter |
| a_dn | output | 1 | Offset counter counting down |
| b_dn | output | 1 | Base counter counting down |
| s_dn | output | 1 | Auxiliary counter counting down |
| s_act | output | 1 | Auxiliary counter active (not held) |
| pwm_p | output | 3 | Positive output per phase |
| pwm_n | output | 3 | Negative output per phase |
| cfg_bad | output | 1 | Configuration illegal (registered) |

## Verification
The main run uses a wide carrier (dead 3, half cycle 20) with duties low, middle and near the crest. This separates correct crest and trough reversal points from off-by-one reversals and checks that each pair keeps its gap at every edge. A short carrier (dead 1, half cycle 3) puts the auxiliary windows next to each other, which exposes a mis-triggered crest or trough start. An irregular step pattern separates true holding from counting on every clock. Duties of 0 and above the period pin the outputs at their extremes, and three separate illegal settings check that each legality rule keeps the counters stopped on its own.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {ZONE_TROUGH = 1'b0, ZONE_CREST = 1'b1} zone_e;
endpackage

// File: rtl/cpwm_tri_cnt.sv
module cpwm_tri_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stop,
  input  logic         step,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] cnt,
  output logic         dn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dn  <= 1'b0;
    end else if (stop) begin
      cnt <= load_val;
      dn  <= 1'b0;
    end else if (step) begin
      if (!dn) begin
        if (cnt == hi) begin
          cnt <= cnt - 1'b1;
          dn  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == lo) begin
          cnt <= cnt + 1'b1;
          dn  <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpwm_aux_cnt.sv
module cpwm_aux_cnt
  import cpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stop,
  input  logic         step,
  input  logic [W-1:0] dead,
  input  logic [W-1:0] half,
  input  logic [W-1:0] per,
  input  logic [W-1:0] a,
  input  logic         a_dn,
  input  logic [W-1:0] b,
  input  logic         b_dn,
  output logic [W-1:0] s,
  output logic         s_dn,
  output logic         s_act
);
  zone_e zone;

  always_ff @(posedge clk) begin
    if (rst) begin
      s     <= '0;
      s_dn  <= 1'b0;
      s_act <= 1'b0;
      zone  <= ZONE_TROUGH;
    end else if (stop) begin
      s     <= dead;
      s_dn  <= 1'b1;
      s_act <= 1'b1;
      zone  <= ZONE_TROUGH;
    end else if (step) begin
      if (!s_act) begin
        if (a == half && !a_dn) begin
          s     <= s - 1'b1;
          s_dn  <= 1'b1;
          s_act <= 1'b1;
          zone  <= ZONE_CREST;
        end else if (b == dead && b_dn) begin
          s     <= s + 1'b1;
          s_dn  <= 1'b0;
          s_act <= 1'b1;
          zone  <= ZONE_TROUGH;
        end
      end else if (zone == ZONE_CREST) begin
        if (s_dn) begin
          if (s == half) begin
            s    <= s + 1'b1;
            s_dn <= 1'b0;
          end else begin
            s <= s - 1'b1;
          end
        end else if (s == per) begin
          s     <= '0;
          s_act <= 1'b0;
        end else begin
          s <= s + 1'b1;
        end
      end else begin
        if (!s_dn) begin
          if (s == dead) begin
            s    <= s - 1'b1;
            s_dn <= 1'b1;
          end else begin
            s <= s + 1'b1;
          end
        end else if (s == '0) begin
          s     <= per;
          s_act <= 1'b0;
        end else begin
          s <= s - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpwm_pair_out.sv
module cpwm_pair_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] duty,
  output logic         p,
  output logic         n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      p <= 1'b0;
      n <= 1'b0;
    end else begin
      p <= go && (a < duty);
      n <= go && (b >= duty);
    end
  end
endmodule

// File: rtl/cpwm_engine.sv
module cpwm_engine #(
  parameter int W      = 16,
  parameter int PHASES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              step,
  input  logic [W-1:0]      dead_time,
  input  logic [W-1:0]      half_cycle,
  input  logic [W-1:0]      period,
  input  logic [PHASES*W-1:0] duty,
  output logic [W-1:0]      cnt_a,
  output logic [W-1:0]      cnt_b,
  output logic [W-1:0]      cnt_s,
  output logic              a_dn,
  output logic              b_dn,
  output logic              s_dn,
  output logic              s_act,
  output logic [PHASES-1:0] pwm_p,
  output logic [PHASES-1:0] pwm_n,
  output logic              cfg_bad
);
  localparam int WX = W + 1;

  logic [WX-1:0] sum_hd;
  logic          legal;
  logic          go;

  assign sum_hd = {1'b0, half_cycle} + {1'b0, dead_time};
  assign legal  = (dead_time != '0) &&
                  ({1'b0, half_cycle} > {dead_time, 1'b0}) &&
                  ({1'b0, period} == sum_hd);
  assign go     = run && legal;

  always_ff @(posedge clk) begin
    if (rst) cfg_bad <= 1'b0;
    else     cfg_bad <= !legal;
  end

  cpwm_tri_cnt #(.W(W)) u_cnt_a (
    .clk(clk), .rst(rst), .stop(!go), .step(step),
    .load_val(dead_time), .lo(dead_time), .hi(period),
    .cnt(cnt_a), .dn(a_dn)
  );

  cpwm_tri_cnt #(.W(W)) u_cnt_b (
    .clk(clk), .rst(rst), .stop(!go), .step(step),
    .load_val('0), .lo('0), .hi(half_cycle),
    .cnt(cnt_b), .dn(b_dn)
  );

  cpwm_aux_cnt #(.W(W)) u_cnt_s (
    .clk(clk), .rst(rst), .stop(!go), .step(step),
    .dead(dead_time), .half(half_cycle), .per(period),
    .a(cnt_a), .a_dn(a_dn), .b(cnt_b), .b_dn(b_dn),
    .s(cnt_s), .s_dn(s_dn), .s_act(s_act)
  );

  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    cpwm_pair_out #(.W(W)) u_pair (
      .clk(clk), .rst(rst), .go(go),
      .a(cnt_a), .b(cnt_b), .duty(duty[i*W +: W]),
      .p(pwm_p[i]), .n(pwm_n[i])
    );
  end
endmodule

// File: rtl/cpwm_engine_chk.sv
module cpwm_engine_chk #(
  parameter int W      = 16,
  parameter int PHASES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              step,
  input logic [W-1:0]      dead_time,
  input logic [W-1:0]      half_cycle,
  input logic [W-1:0]      period,
  input logic [W-1:0]      cnt_a,
  input logic [W-1:0]      cnt_b,
  input logic [W-1:0]      cnt_s,
  input logic              a_dn,
  input logic              b_dn,
  input logic              s_dn,
  input logic              s_act,
  input logic [PHASES-1:0] pwm_p,
  input logic [PHASES-1:0] pwm_n,
  input logic              cfg_bad
);
  logic          legal, go_now, steady;
  logic [W-1:0]  dq, hq, pq;

  assign legal  = (dead_time != '0) && ({1'b0, half_cycle} > {dead_time, 1'b0}) &&
                  ({1'b0, period} == ({1'b0, half_cycle} + {1'b0, dead_time}));
  assign go_now = run && legal;

  always_ff @(posedge clk) begin
    dq <= dead_time;
    hq <= half_cycle;
    pq <= period;
    if (rst)          steady <= 1'b0;
    else if (!go_now) steady <= 1'b1;
    else              steady <= steady && dead_time == dq && half_cycle == hq && period == pq;
  end

  a_r1_preload: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_a == $past(dead_time) && cnt_b == '0 && cnt_s == $past(dead_time) &&
              !a_dn && !b_dn && s_dn && s_act));

  a_r2_a_range: assert property (@(posedge clk) disable iff (rst)
    steady |-> (cnt_a >= dq && cnt_a <= pq));

  a_r3_lockstep: assert property (@(posedge clk) disable iff (rst)
    steady |-> ({1'b0, cnt_a} == {1'b0, cnt_b} + {1'b0, dq}));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (steady && go_now && !step) |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_s)));

  a_r5_aux_range: assert property (@(posedge clk) disable iff (rst)
    steady |-> cnt_s <= pq);

  a_r7_illegal_stops: assert property (@(posedge clk) disable iff (rst)
    !legal |=> (cfg_bad && cnt_a == $past(dead_time) && cnt_b == '0));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (pwm_p & pwm_n) == '0);

  a_r9_outputs_off: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_p == '0 && pwm_n == '0));
endmodule

bind cpwm_engine cpwm_engine_chk #(.W(W), .PHASES(PHASES)) u_chk (
  .clk(clk), .rst(rst), .run(run), .step(step),
  .dead_time(dead_time), .half_cycle(half_cycle), .period(period),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_s(cnt_s),
  .a_dn(a_dn), .b_dn(b_dn), .s_dn(s_dn), .s_act(s_act),
  .pwm_p(pwm_p), .pwm_n(pwm_n), .cfg_bad(cfg_bad)
);

// File: tb/cpwm_engine_tb.sv
`timescale 1ns/1ps
module cpwm_engine_tb;
  localparam int W = 16;
  localparam int PH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic step = 1'b1;
  logic [W-1:0] dead_time = 3, half_cycle = 20, period = 23;
  logic [PH*W-1:0] duty = '0;
  logic [W-1:0] cnt_a, cnt_b, cnt_s;
  logic a_dn, b_dn, s_dn, s_act, cfg_bad;
  logic [PH-1:0] pwm_p, pwm_n;

  always #4 clk = ~clk;

  cpwm_engine #(.W(W), .PHASES(PH)) u_dut (
    .clk(clk), .rst(rst), .run(run), .step(step),
    .dead_time(dead_time), .half_cycle(half_cycle), .period(period), .duty(duty),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_s(cnt_s),
    .a_dn(a_dn), .b_dn(b_dn), .s_dn(s_dn), .s_act(s_act),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .cfg_bad(cfg_bad)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string ph = "R1";

  // behavioural reference state
  int ma, mb, ms, mad, mbd, msd, mact, mcrest, mbad;
  int mp [PH];
  int mn [PH];

  task automatic chk(string tag, int got, int exp, string what);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  function automatic string tg(string dflt);
    return (ph == "") ? dflt : ph;
  endfunction

  always @(posedge clk) begin
    int d, h, p, lg, g, na, nad, nb, nbd, ns, nsd, nact, ncrest;
    cyc++;
    d = int'(dead_time); h = int'(half_cycle); p = int'(period);
    if (rst) begin
      ma = 0; mb = 0; ms = 0; mad = 0; mbd = 0; msd = 0; mact = 0; mcrest = 0; mbad = 0;
      for (int i = 0; i < PH; i++) begin mp[i] = 0; mn[i] = 0; end
    end else begin
      lg = (d > 0 && h > 2 * d && p == h + d) ? 1 : 0;
      g = (run && lg) ? 1 : 0;
      mbad = lg ? 0 : 1;
      for (int i = 0; i < PH; i++) begin
        mp[i] = (g && ma < int'(duty[i*W +: W])) ? 1 : 0;
        mn[i] = (g && mb >= int'(duty[i*W +: W])) ? 1 : 0;
      end
      if (!g) begin
        ma = d; mad = 0; mb = 0; mbd = 0; ms = d; msd = 1; mact = 1; mcrest = 0;
      end else if (step) begin
        na = ma; nad = mad; nb = mb; nbd = mbd; ns = ms; nsd = msd; nact = mact; ncrest = mcrest;
        if (mad == 0) begin if (ma == p) begin na = ma - 1; nad = 1; end else na = ma + 1; end
        else begin if (ma == d) begin na = ma + 1; nad = 0; end else na = ma - 1; end
        if (mbd == 0) begin if (mb == h) begin nb = mb - 1; nbd = 1; end else nb = mb + 1; end
        else begin if (mb == 0) begin nb = 1; nbd = 0; end else nb = mb - 1; end
        if (mact == 0) begin
          if (ma == h && mad == 0) begin ns = ms - 1; nsd = 1; nact = 1; ncrest = 1; end
          else if (mb == d && mbd == 1) begin ns = ms + 1; nsd = 0; nact = 1; ncrest = 0; end
        end else if (mcrest == 1) begin
          if (msd == 1) begin if (ms == h) begin ns = ms + 1; nsd = 0; end else ns = ms - 1; end
          else begin if (ms == p) begin ns = 0; nact = 0; end else ns = ms + 1; end
        end else begin
          if (msd == 0) begin if (ms == d) begin ns = ms - 1; nsd = 1; end else ns = ms + 1; end
          else begin if (ms == 0) begin ns = p; nact = 0; end else ns = ms - 1; end
        end
        ma = na; mad = nad; mb = nb; mbd = nbd; ms = ns; msd = nsd; mact = nact; mcrest = ncrest;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    chk(tg("R2"), int'(cnt_a), ma, "cnt_a");
    chk(tg("R2"), int'(a_dn), mad, "a_dn");
    chk(tg("R3"), int'(cnt_b), mb, "cnt_b");
    chk(tg("R3"), int'(b_dn), mbd, "b_dn");
    chk(tg("R5"), int'(cnt_s), ms, "cnt_s");
    chk(tg("R6"), int'(s_dn), msd, "s_dn");
    chk(tg("R6"), int'(s_act), mact, "s_act");
    chk(tg("R7"), int'(cfg_bad), mbad, "cfg_bad");
    for (int i = 0; i < PH; i++) begin
      chk(tg("R8"), int'(pwm_p[i]), mp[i], $sformatf("pwm_p[%0d]", i));
      chk(tg("R8"), int'(pwm_n[i]), mn[i], $sformatf("pwm_n[%0d]", i));
    end
    chk("R8", int'(pwm_p & pwm_n), 0, "pair overlap");
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(int d, int h, int p);
    dead_time = W'(d); half_cycle = W'(h); period = W'(p);
  endtask

  task automatic set_duty(int x, int y, int z);
    duty = {W'(z), W'(y), W'(x)};
  endtask

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    set_duty(5, 12, 19);
    // R1: reset state and preload while stopped
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(10);
    // main function, wide carrier: R2 R3 R5 R6 R8
    ph = "";
    run = 1'b1;
    wait_cycles(300);
    // R4: irregular step pattern
    ph = "R4";
    for (int k = 0; k < 200; k++) begin
      step = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      @(negedge clk);
    end
    step = 1'b1;
    // R9: stop mid run
    ph = "R9";
    run = 1'b0;
    wait_cycles(6);
    // R8 boundary duties: 0 and above period
    ph = "";
    set_duty(0, 24, 10);
    run = 1'b1;
    wait_cycles(120);
    // R7: three illegal settings while run stays high
    ph = "R7";
    set_cfg(3, 20, 22);
    wait_cycles(20);
    set_cfg(0, 20, 20);
    wait_cycles(20);
    set_cfg(5, 10, 15);
    wait_cycles(20);
    // short carrier with adjacent dead-time windows
    ph = "R1";
    run = 1'b0;
    set_cfg(1, 3, 4);
    set_duty(1, 2, 4);
    wait_cycles(3);
    ph = "";
    run = 1'b1;
    wait_cycles(80);
    // R6 preload and restart on another legal carrier
    ph = "";
    run = 1'b0;
    set_cfg(2, 7, 9);
    set_duty(3, 6, 9);
    wait_cycles(2);
    run = 1'b1;
    wait_cycles(100);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule